// File: doc/BRIEF.md
# Receive-FIFO Serial Port Register Front End

This block is the register-side front end of a byte-oriented serial port. A processor reaches it over a simple synchronous register bus with address, write strobe, read strobe, write data and registered read data. Behind the registers sit a 16-entry receive queue with a selectable fill threshold, a one-byte transmit stream, and a small set of status flags. Status flags are cleared by writing zero to them. The line side (bit timing, framing, parity) lives elsewhere. The divisor register here is only held for that logic to use.

Received bytes arrive on a valid/ready stream. `rx_ready` is high exactly while the receive-enable control bit is set. When `rx_valid` and `rx_ready` are both high at a clock edge, the byte is consumed. If the queue already holds 16 bytes, the byte is discarded rather than back-pressured. Transmit bytes leave on a valid/ready stream. `tx_valid` rises after a write to the transmit data register and holds, with `tx_data` stable, until the edge where `tx_ready` is high. A newer write before that edge replaces the pending byte.

A read strobe at a clock edge returns the addressed value on `bus_rdata` after that edge. The value stays there until the next read.

Top module: `serport_regfront`

## Requirements
- R1: After reset, divisor (0x04) reads 0xFF, control (0x08) reads 0x20, status (0x10) reads 0x60, FIFO control (0x18) and count (0x1C) read 0, and both interrupt outputs and `rx_ready` are low.
- R2: Writes are masked: mode (0x00) keeps bits of 0x7B, control keeps 0xFA, port (0x20) keeps 0xF3. The divisor and the 16-bit FIFO control register store the whole value. Line status (0x24), transmit data (0x0C) and unmapped offsets read 0. Writes to unmapped offsets change nothing.
- R3: The queue returns bytes in arrival order at offset 0x14. Each accepted byte increments the count at 0x1C and each pop decrements it. A byte arriving while 16 are held is dropped, and the count stays 16.
- R4: A receive byte is taken only while control bit 4 is 1, and `rx_ready` mirrors that bit.
- R5: FIFO control bits 7:6 pick the threshold: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. Status bit 1 (receive-full) is set when an accepted byte brings the count to the threshold or above. It is cleared when a pop brings the count below the threshold.
- R6: `rx_irq` rises when receive-full is set by an arriving byte while control bit 6 is 1. It stays high until a status write with bit 1 or bit 0 at zero, or until a control write with bit 6 at zero.
- R7: A status write clears each of bits 6 (transmit end), 5 (transmit empty), 4 (break) and 1 (receive-full) that is written 0, and leaves those written 1 unchanged. Bit 0 (data-ready) always reads 0.
- R8: A write to 0x0C presents its low byte on the transmit stream and clears transmit-empty. One cycle after the handshake, transmit-empty and transmit-end are set if control bit 5 is 1.
- R9: `tx_irq` equals control bit 7. A control write with bit 5 at zero sets transmit-end.
- R10: Writing FIFO control with bit 1 set empties the queue, so the count becomes 0. The status flags are left unchanged.
- R11: A read of 0x14 while the queue is empty returns 0 and leaves the count at 0.
- R12: A one-cycle `brk_pulse` sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid after the read edge |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive enabled |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmit byte taken |
| tx_data | output | 8 | Transmit byte |
| brk_pulse | input | 1 | Line break detected |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
Every cycle, the assertions check these invariants:
- The queue count never exceeds the depth.
- A full queue does not grow.
- A flush or an empty-queue pop leaves the queue empty.
- An arriving byte that reaches the threshold raises receive-full.
- `rx_irq` is never high without its enable bit.
- A break pulse and a transmit load move their flags.
- A pending transmit byte holds steady under back-pressure.

Only the bench scenarios can show the arrival order of the data, the set and clear of the threshold at each of the four levels, the write masks, and the write-zero-to-clear behaviour of each status bit. They also show the timing of transmit completion after the handshake.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam int OFF_MODE = 'h00;
  localparam int OFF_BAUD = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_TXD  = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_RXD  = 'h14;
  localparam int OFF_FCTL = 'h18;
  localparam int OFF_CNT  = 'h1C;
  localparam int OFF_PORT = 'h20;
  localparam int OFF_LSR  = 'h24;

  localparam logic [7:0] MASK_MODE = 8'h7B;
  localparam logic [7:0] MASK_CTRL = 8'hFA;
  localparam logic [7:0] MASK_PORT = 8'hF3;

  // status bit positions
  localparam int FB_TEND = 6;
  localparam int FB_TDE  = 5;
  localparam int FB_BRK  = 4;
  localparam int FB_RDF  = 1;
  localparam int FB_DR   = 0;

  // control bit positions
  localparam int CB_RE  = 4;
  localparam int CB_TE  = 5;
  localparam int CB_RIE = 6;
  localparam int CB_TIE = 7;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
  parameter int DEPTH = 16,
  parameter int BW    = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [BW-1:0]    push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [BW-1:0]    head_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             push_acc,
  output logic             pop_acc
);

  logic [BW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;
  logic             full, empty;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  assign push_acc = push && !full && !flush;
  assign pop_acc  = pop && !empty && !flush;

  generate
    if (DEPTH == (1 << PTR_W)) begin : g_wrap_pow2
      assign wr_inc = wr_ptr + 1'b1;
      assign rd_inc = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_nxt = count;
    if (flush)
      cnt_nxt = '0;
    else if (push_acc && !pop_acc)
      cnt_nxt = count + 1'b1;
    else if (pop_acc && !push_acc)
      cnt_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_acc)
      mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_inc;
      if (pop_acc)  rd_ptr <= rd_inc;
      count <= cnt_nxt;
    end
  end

  assign head_data = empty ? '0 : mem[rd_ptr];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> full); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R10
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty); // R11

endmodule

// File: rtl/serport_stat.sv
module serport_stat #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_wr,
  input  logic             keep_tend,
  input  logic             keep_tde,
  input  logic             keep_brk,
  input  logic             keep_rdf,
  input  logic             keep_dr,
  input  logic             ctrl_wr,
  input  logic             ctrl_te_new,
  input  logic             ctrl_rie_new,
  input  logic             te,
  input  logic             rie,
  input  logic             tx_load,
  input  logic             tx_done,
  input  logic             brk,
  input  logic             push_acc,
  input  logic             pop_acc,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] trig,
  output logic [7:0]       flags,
  output logic             rx_irq
);
  import serport_pkg::*;

  logic tend_q, tde_q, brk_q, rdf_q, irq_q;
  logic tend_n, tde_n, brk_n, rdf_n, irq_n;
  logic rie_eff, reach;

  assign rie_eff = ctrl_wr ? ctrl_rie_new : rie;
  assign reach   = push_acc && (cnt_nxt >= trig);

  always_comb begin
    tend_n = tend_q;
    tde_n  = tde_q;
    brk_n  = brk_q;
    rdf_n  = rdf_q;
    irq_n  = irq_q;
    if (st_wr) begin
      if (!keep_tend) tend_n = 1'b0;
      if (!keep_tde)  tde_n  = 1'b0;
      if (!keep_brk)  brk_n  = 1'b0;
      if (!keep_rdf)  rdf_n  = 1'b0;
      if (!keep_rdf || !keep_dr) irq_n = 1'b0;
    end
    if (ctrl_wr && !ctrl_te_new)  tend_n = 1'b1;
    if (ctrl_wr && !ctrl_rie_new) irq_n  = 1'b0;
    if (tx_done && te) begin
      tend_n = 1'b1;
      tde_n  = 1'b1;
    end
    if (tx_load) tde_n = 1'b0;
    if (brk)     brk_n = 1'b1;
    if (pop_acc && (cnt_nxt < trig)) rdf_n = 1'b0;
    if (reach) begin
      rdf_n = 1'b1;
      if (rie_eff) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      tde_q  <= 1'b1;
      brk_q  <= 1'b0;
      rdf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tend_q <= tend_n;
      tde_q  <= tde_n;
      brk_q  <= brk_n;
      rdf_q  <= rdf_n;
      irq_q  <= irq_n;
    end
  end

  always_comb begin
    flags          = '0;
    flags[FB_TEND] = tend_q;
    flags[FB_TDE]  = tde_q;
    flags[FB_BRK]  = brk_q;
    flags[FB_RDF]  = rdf_q;
    flags[FB_DR]   = 1'b0;
  end
  assign rx_irq = irq_q;

  AST_RDF_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> flags[FB_RDF]); // R5
  AST_IRQ_NEEDS_RIE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rie); // R6
  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> flags[FB_BRK]); // R12
  AST_TDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !flags[FB_TDE]); // R8

endmodule

// File: rtl/serport_regfront.sv
module serport_regfront #(
  parameter int ADDR_W = 6,
  parameter int DW     = 16,
  parameter int BW     = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BW-1:0]     rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BW-1:0]     tx_data,
  input  logic              brk_pulse,
  output logic              rx_irq,
  output logic              tx_irq
);
  import serport_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(OFF_BAUD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFF_TXD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFF_RXD);
  localparam logic [ADDR_W-1:0] A_FCTL = ADDR_W'(OFF_FCTL);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFF_PORT);
  localparam logic [ADDR_W-1:0] A_LSR  = ADDR_W'(OFF_LSR);

  logic [BW-1:0]    mode_q, baud_q, ctrl_q, port_q, txd_q;
  logic [DW-1:0]    fctl_q, rd_mux, rdata_q;
  logic             txv_q, txdone_q;
  logic [BW-1:0]    wbyte, head_data;
  logic [CNT_W-1:0] count, cnt_nxt, trig;
  logic [7:0]       flags;
  logic             w_ctrl, w_txd, w_stat, w_fctl, rd_pop, flush;
  logic             push_acc, pop_acc, tx_hs;

  assign wbyte  = bus_wdata[BW-1:0];
  assign w_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign w_txd  = bus_wr && (bus_addr == A_TXD);
  assign w_stat = bus_wr && (bus_addr == A_STAT);
  assign w_fctl = bus_wr && (bus_addr == A_FCTL);
  assign rd_pop = bus_rd && (bus_addr == A_RXD);
  assign flush  = w_fctl && bus_wdata[1];
  assign tx_hs  = txv_q && tx_ready;

  assign trig     = CNT_W'(trig_level(fctl_q[7:6]));
  assign rx_ready = ctrl_q[CB_RE];
  assign tx_irq   = ctrl_q[CB_TIE];
  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      baud_q <= 8'hFF;
      ctrl_q <= 8'h20;
      port_q <= '0;
      fctl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q <= wbyte & MASK_MODE;
        A_BAUD:  baud_q <= wbyte;
        A_CTRL:  ctrl_q <= wbyte & MASK_CTRL;
        A_FCTL:  fctl_q <= bus_wdata;
        A_PORT:  port_q <= wbyte & MASK_PORT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd_q    <= '0;
      txv_q    <= 1'b0;
      txdone_q <= 1'b0;
    end else begin
      txdone_q <= tx_hs;
      if (w_txd) begin
        txd_q <= wbyte;
        txv_q <= 1'b1;
      end else if (tx_hs) begin
        txv_q <= 1'b0;
      end
    end
  end

  serport_rxq #(.DEPTH(DEPTH), .BW(BW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid && rx_ready),
    .push_data (rx_data),
    .pop       (rd_pop),
    .flush     (flush),
    .head_data (head_data),
    .count     (count),
    .cnt_nxt   (cnt_nxt),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc)
  );

  serport_stat #(.CNT_W(CNT_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_wr        (w_stat),
    .keep_tend    (bus_wdata[FB_TEND]),
    .keep_tde     (bus_wdata[FB_TDE]),
    .keep_brk     (bus_wdata[FB_BRK]),
    .keep_rdf     (bus_wdata[FB_RDF]),
    .keep_dr      (bus_wdata[FB_DR]),
    .ctrl_wr      (w_ctrl),
    .ctrl_te_new  (bus_wdata[CB_TE]),
    .ctrl_rie_new (bus_wdata[CB_RIE]),
    .te           (ctrl_q[CB_TE]),
    .rie          (ctrl_q[CB_RIE]),
    .tx_load      (w_txd),
    .tx_done      (txdone_q),
    .brk          (brk_pulse),
    .push_acc     (push_acc),
    .pop_acc      (pop_acc),
    .cnt_nxt      (cnt_nxt),
    .trig         (trig),
    .flags        (flags),
    .rx_irq       (rx_irq)
  );

  always_comb begin
    case (bus_addr)
      A_MODE:  rd_mux = DW'(mode_q);
      A_BAUD:  rd_mux = DW'(baud_q);
      A_CTRL:  rd_mux = DW'(ctrl_q);
      A_STAT:  rd_mux = DW'(flags);
      A_RXD:   rd_mux = DW'(head_data);
      A_FCTL:  rd_mux = fctl_q;
      A_CNT:   rd_mux = DW'(count);
      A_PORT:  rd_mux = DW'(port_q);
      A_LSR:   rd_mux = '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txv_q && !tx_ready && !w_txd |=> txv_q && $stable(txd_q)); // R8
  AST_TX_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    txdone_q && ctrl_q[CB_TE] && !w_txd |=> flags[FB_TDE] && flags[FB_TEND]); // R8

endmodule

// File: tb/serport_regfront_bench.sv
module serport_regfront_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        brk_pulse, rx_irq, tx_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  serport_regfront u_serport_regfront (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .brk_pulse(brk_pulse), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_addr = 6'(addr); bus_wdata = 16'(data); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    bus_addr = 6'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    data = int'(bus_rdata);
  endtask

  task automatic push(input int b);
    @(negedge clk);
    rx_data = 8'(b); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int v, cnt, tl;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; tx_ready = 0; brk_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h04, v); check("R1 divisor", v, 'hFF);
    rd('h08, v); check("R1 control", v, 'h20);
    rd('h10, v); check("R1 status", v, 'h60);
    rd('h18, v); check("R1 fifo ctrl", v, 0);
    rd('h1C, v); check("R1 count", v, 0);
    check("R1 rx_irq", int'(rx_irq), 0);
    check("R1 tx_irq", int'(tx_irq), 0);
    check("R1 rx_ready", int'(rx_ready), 0);

    // R2 masks and map
    wr('h00, 'hFF); rd('h00, v); check("R2 mode mask", v, 'h7B);
    wr('h20, 'hFF); rd('h20, v); check("R2 port mask", v, 'hF3);
    wr('h04, 'h3C); rd('h04, v); check("R2 divisor", v, 'h3C);
    rd('h24, v); check("R2 line status", v, 0);
    rd('h28, v); check("R2 unmapped read", v, 0);
    wr('h2C, 'hFFFF); rd('h00, v); check("R2 unmapped write", v, 'h7B);
    wr('h18, 'hAB00); rd('h18, v); check("R2 fifo ctrl 16 bit", v, 'hAB00);
    wr('h08, 'hFF); rd('h08, v); check("R2 control mask", v, 'hFA);
    check("R9 tx_irq high", int'(tx_irq), 1);

    // R4 receive disabled
    wr('h18, 'h02);
    wr('h08, 'h60);
    check("R9 tx_irq low", int'(tx_irq), 0);
    check("R4 rx_ready low", int'(rx_ready), 0);
    push('h55); rd('h1C, v); check("R4 dropped while disabled", v, 0);
    wr('h08, 'h70);
    check("R4 rx_ready high", int'(rx_ready), 1);

    // R3 R5 R6 sweep over all threshold selections
    for (int sel = 0; sel < 4; sel++) begin
      tl = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
      wr('h18, (sel << 6) | 2);
      wr('h10, 'hFC);
      check("R6 irq cleared by status", int'(rx_irq), 0);
      for (int k = 1; k <= 18; k++) begin
        push(sel * 32 + k);
        cnt = (k > 16) ? 16 : k;
        rd('h1C, v); check("R3 count on push", v, cnt);
        rd('h10, v); check("R5 rdf on push", (v >> 1) & 1, (cnt >= tl) ? 1 : 0);
        check("R6 rx_irq on push", int'(rx_irq), (cnt >= tl) ? 1 : 0);
      end
      for (int k = 1; k <= 16; k++) begin
        rd('h14, v); check("R3 order", v, sel * 32 + k);
        cnt = 16 - k;
        rd('h1C, v); check("R3 count on pop", v, cnt);
        rd('h10, v); check("R5 rdf on pop", (v >> 1) & 1, (cnt >= tl) ? 1 : 0);
      end
      check("R6 irq survives pops", int'(rx_irq), 1);
      rd('h14, v); check("R11 empty read data", v, 0);
      rd('h1C, v); check("R11 empty read count", v, 0);
    end

    // R7 write-zero-to-clear
    wr('h18, 'h02);
    push('h11);
    wr('h10, 'hFD);
    rd('h10, v); check("R7 clear rdf only", v, 'h60);
    check("R6 irq cleared by rdf write", int'(rx_irq), 0);
    wr('h10, 'h9F);
    rd('h10, v); check("R7 clear tend tde", v, 'h00);
    wr('h10, 'hFF);
    rd('h10, v); check("R7 ones keep", v, 'h00);

    // R12 break
    @(negedge clk); brk_pulse = 1'b1;
    @(negedge clk); brk_pulse = 1'b0;
    rd('h10, v); check("R12 break set", v, 'h10);
    wr('h10, 'hEF);
    rd('h10, v); check("R7 break cleared", v, 'h00);

    // R10 flush
    push(1); push(2); push(3);
    rd('h1C, v); check("R10 count before flush", v, 4);
    wr('h18, 'h02);
    rd('h1C, v); check("R10 count after flush", v, 0);
    rd('h10, v); check("R10 flags kept", v, 'h02);
    wr('h10, 'hFD);

    // R8 transmit
    wr('h0C, 'h1A5);
    check("R8 tx_valid", int'(tx_valid), 1);
    check("R8 tx_data", int'(tx_data), 'hA5);
    rd('h10, v); check("R8 tde cleared", v, 'h00);
    repeat (3) @(negedge clk);
    check("R8 tx held", int'(tx_valid), 1);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    check("R8 tx taken", int'(tx_valid), 0);
    @(negedge clk);
    rd('h10, v); check("R8 completion flags", v, 'h60);

    // R9 control bit 5 clear sets transmit end
    wr('h10, 'hBF);
    rd('h10, v); check("R9 tend cleared", v, 'h20);
    wr('h08, 'h50);
    rd('h10, v); check("R9 tend set by control", v, 'h60);
    wr('h08, 'hD0);
    check("R9 tx_irq follows bit7", int'(tx_irq), 1);

    // R6 control write clears irq
    wr('h08, 'h70);
    push('h22);
    check("R6 irq raised", int'(rx_irq), 1);
    wr('h08, 'h30);
    check("R6 irq cleared by control", int'(rx_irq), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule